// File: doc/BRIEF.md
# HDLC Receive Byte Buffer with Status Register

This block sits after an HDLC deframer. The deframer finds the flags, removes the stuffed zero bits and checks the CRC, and this block stores what is left. For each payload byte the deframer raises a strobe and supplies the byte with two markers, one for the start of a message and one for its end. The end-of-message byte also carries a CRC verdict. A separate one-cycle pulse reports an abort, meaning a run of seven or more ones on the line.

The block writes each accepted byte into a 16-entry FIFO. Beside the byte it stores three tags: first byte of a message, last byte of a message, and last byte of a good message. A good message is one with a correct CRC in which no abort and no dropped byte occurred. A processor reads two 8-bit registers over a one-bit select and a read strobe:

- The status register shows four sticky event flags, a live empty indication, and the three tags of the byte at the head of the FIFO.
- The data register returns the head byte, and reading it removes that byte.

Top module: `hdlc_rx_fifo_stat`

## Requirements
- R1: The status register (rd_sel = 0) reads, from bit 7 down to bit 0: abort, CRC error, overrun, valid message, empty, packet good, closing byte, opening byte.
- R2: After reset the status register reads 0x08. The empty bit (bit 3) is live and is 1 exactly when the FIFO holds no byte.
- R3: Up to 16 bytes are held in arrival order. Reading the data register (rd_sel = 1) returns the head byte combinationally. The read strobe pops that byte at the clock edge, and the head and its tags change from the next cycle on.
- R4: The opening tag (bit 0) is 1 when the head byte arrived with the start marker.
- R5: The closing tag (bit 1) is 1 when the head byte arrived with the end marker, whatever the CRC verdict.
- R6: The packet-good tag (bit 2) is 1 only when all of the following hold for the head byte:
  - it arrived with the end marker and a good CRC verdict;
  - no abort pulse occurred since the last start marker or message end;
  - no byte was dropped since the last start marker or message end.
- R7: When a byte strobe finds the FIFO full and no pop happens in the same cycle, the byte is dropped and the overrun flag (bit 5) is set. A pop and a write in the same cycle at full both take effect, and no overrun is raised.
- R8: An abort pulse sets the abort flag (bit 7) and marks the current message as bad.
- R9: An end-marked byte with a bad CRC verdict sets the CRC error flag (bit 6).
- R10: Every end-marked byte strobe sets the valid-message flag (bit 4).
- R11: Bits 7 to 4 hold until the status register is read with the strobe, which clears them. An event in the same cycle as that read leaves its flag set.
- R12: A data read while the FIFO is empty returns 0x00 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_vld | input | 1 | Byte strobe from the deframer |
| in_byte | input | 8 | Payload byte |
| in_som | input | 1 | Byte is the first of a message |
| in_eom | input | 1 | Byte is the last of a message |
| in_crc_ok | input | 1 | CRC verdict, meaningful with in_eom |
| in_abort | input | 1 | One-cycle abort event |
| rd_stb | input | 1 | Register read strobe, side effect at the clock edge |
| rd_sel | input | 1 | 0 selects status, 1 selects data |
| rd_data | output | 8 | Selected register value (combinational) |

## Verification
Two pairs of operations can land in the same cycle. The first pair is a data-register pop and an incoming byte while the FIFO is full. The bench fills all 16 entries and then drives the pop and the byte strobe on the same edge. It passes only if the overrun flag stays clear and that byte later comes out as the sixteenth. The second pair is a clearing status read and an abort pulse. The bench drives both on one edge and expects the abort flag to be set on the following status read.

// File: rtl/hrx_pkg.sv
// Package: shared entry type and status bit positions for the HDLC
// receive buffer. Assumes 8-bit payload bytes.
package hrx_pkg;
    localparam int BYTE_W = 8;

    // One FIFO entry: payload byte plus three boundary/validity tags.
    typedef struct packed {
        logic              open_t;
        logic              close_t;
        logic              good_t;
        logic [BYTE_W-1:0] data;
    } hrx_entry_t;

    localparam int ENTRY_W = $bits(hrx_entry_t);

    // Status register bit positions.
    localparam int ST_ABT   = 7;
    localparam int ST_CRCE  = 6;
    localparam int ST_OVR   = 5;
    localparam int ST_VM    = 4;
    localparam int ST_EMPTY = 3;
    localparam int ST_GOOD  = 2;
    localparam int ST_CLOSE = 1;
    localparam int ST_OPEN  = 0;
endpackage

// File: rtl/hrx_fifo.sv
// Module: hrx_fifo
// Synchronous FIFO of DEPTH entries, WIDTH bits wide, head shown without
// latency. Assumes the writer never writes when full unless it pops in
// the same cycle, and the reader never pops when empty.
module hrx_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;

    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));
    assign head  = mem[rd_ptr];

    // Storage write; contents need no reset since the head is masked when empty.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_data;
    end

    // Pointer and occupancy tracking with wrap at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (rd_en) rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({wr_en, rd_en})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (!full || rd_en));
    // R12
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty);
    // R3
    pop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/hrx_tagger.sv
// Module: hrx_tagger
// Decides whether each incoming byte is stored and builds its tags. It
// tracks whether the message in progress has been spoiled by an abort or
// a dropped byte, and raises one-cycle event pulses for the status flags.
// Assumes in_crc_ok is only meaningful together with in_eom.
module hrx_tagger
    import hrx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_som,
    input  logic              in_eom,
    input  logic              in_crc_ok,
    input  logic              in_abort,
    input  logic              fifo_full,
    input  logic              pop,
    output logic              wr_en,
    output hrx_entry_t        wr_entry,
    output logic              evt_abt,
    output logic              evt_crce,
    output logic              evt_ovr,
    output logic              evt_vm
);
    logic msg_bad;
    logic room, drop, bad_now;

    // Space exists if not full or the head leaves in this same cycle.
    always_comb begin
        room    = !fifo_full || pop;
        drop    = in_vld && !room;
        wr_en   = in_vld && room;
        bad_now = (msg_bad && !in_som) || in_abort;
    end

    // Entry assembly for the byte being written.
    always_comb begin
        wr_entry.data    = in_byte;
        wr_entry.open_t  = in_som;
        wr_entry.close_t = in_eom;
        wr_entry.good_t  = in_eom && in_crc_ok && !bad_now;
    end

    // Event pulses towards the sticky flags.
    always_comb begin
        evt_abt  = in_abort;
        evt_ovr  = drop;
        evt_vm   = in_vld && in_eom;
        evt_crce = in_vld && in_eom && !in_crc_ok;
    end

    // Message-spoiled tracking: set by abort or drop, cleared at a boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_bad <= 1'b0;
        end else if (in_abort) begin
            msg_bad <= 1'b1;
        end else if (drop && !in_eom) begin
            msg_bad <= 1'b1;
        end else if (in_vld && (in_eom || in_som)) begin
            msg_bad <= 1'b0;
        end
    end

    // R6
    good_needs_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_entry.good_t) |-> (wr_entry.close_t && !in_abort));
    // R8
    abort_spoils_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_abort && !(in_vld && in_som)) |=> msg_bad);
endmodule

// File: rtl/hrx_regs.sv
// Module: hrx_regs
// Processor-side register file. Holds the four sticky event flags,
// assembles the status byte from them and the FIFO head, muxes the read
// data and turns a data-register read into a FIFO pop.
// Assumes rd_stb is high for one cycle per intended read side effect.
module hrx_regs
    import hrx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic              rd_sel,
    input  hrx_entry_t        head,
    input  logic              empty,
    input  logic              evt_abt,
    input  logic              evt_crce,
    input  logic              evt_ovr,
    input  logic              evt_vm,
    output logic              pop,
    output logic [BYTE_W-1:0] rd_data
);
    logic abt_q, crce_q, ovr_q, vm_q;
    logic clr;
    logic [7:0] status;

    // Read side effects: a status read clears, a data read pops when not empty.
    always_comb begin
        clr = rd_stb && !rd_sel;
        pop = rd_stb && rd_sel && !empty;
    end

    // Status byte assembly; head tags masked while empty.
    always_comb begin
        status           = '0;
        status[ST_ABT]   = abt_q;
        status[ST_CRCE]  = crce_q;
        status[ST_OVR]   = ovr_q;
        status[ST_VM]    = vm_q;
        status[ST_EMPTY] = empty;
        status[ST_GOOD]  = !empty && head.good_t;
        status[ST_CLOSE] = !empty && head.close_t;
        status[ST_OPEN]  = !empty && head.open_t;
    end

    // Read data mux.
    always_comb begin
        if (rd_sel) rd_data = empty ? '0 : head.data;
        else        rd_data = status;
    end

    // Sticky flags: event sets, clear-on-read clears, event wins a tie.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abt_q  <= 1'b0;
            crce_q <= 1'b0;
            ovr_q  <= 1'b0;
            vm_q   <= 1'b0;
        end else begin
            abt_q  <= evt_abt  || (abt_q  && !clr);
            crce_q <= evt_crce || (crce_q && !clr);
            ovr_q  <= evt_ovr  || (ovr_q  && !clr);
            vm_q   <= evt_vm   || (vm_q   && !clr);
        end
    end

    // R11
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (abt_q && !clr) |=> abt_q);
    // R11
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_ovr && clr) |=> ovr_q);
    // R9
    crce_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_crce |=> crce_q);
endmodule

// File: rtl/hdlc_rx_fifo_stat.sv
// Module: hdlc_rx_fifo_stat (top)
// HDLC receive byte buffer with a status register and a data register.
// Assumes the upstream deframer has already removed flags and stuffed zero
// bits and has checked the CRC; abort arrives as a one-cycle pulse.
module hdlc_rx_fifo_stat
    import hrx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_vld,
    input  logic [7:0]  in_byte,
    input  logic        in_som,
    input  logic        in_eom,
    input  logic        in_crc_ok,
    input  logic        in_abort,
    input  logic        rd_stb,
    input  logic        rd_sel,
    output logic [7:0]  rd_data
);
    logic       wr_en, pop, empty, full;
    hrx_entry_t wr_entry, head;
    logic       evt_abt, evt_crce, evt_ovr, evt_vm;
    logic [ENTRY_W-1:0] head_bits;

    assign head = hrx_entry_t'(head_bits);

    hrx_tagger u_tagger (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_vld    (in_vld),
        .in_byte   (in_byte),
        .in_som    (in_som),
        .in_eom    (in_eom),
        .in_crc_ok (in_crc_ok),
        .in_abort  (in_abort),
        .fifo_full (full),
        .pop       (pop),
        .wr_en     (wr_en),
        .wr_entry  (wr_entry),
        .evt_abt   (evt_abt),
        .evt_crce  (evt_crce),
        .evt_ovr   (evt_ovr),
        .evt_vm    (evt_vm)
    );

    hrx_fifo #(.DEPTH(DEPTH), .WIDTH(ENTRY_W)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_entry),
        .rd_en   (pop),
        .head    (head_bits),
        .empty   (empty),
        .full    (full)
    );

    hrx_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_stb   (rd_stb),
        .rd_sel   (rd_sel),
        .head     (head),
        .empty    (empty),
        .evt_abt  (evt_abt),
        .evt_crce (evt_crce),
        .evt_ovr  (evt_ovr),
        .evt_vm   (evt_vm),
        .pop      (pop),
        .rd_data  (rd_data)
    );

    // R2
    empty_reset_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (rd_sel || rd_data[ST_EMPTY]));
endmodule

// File: tb/tb_hdlc_rx_fifo_stat.sv
module tb_hdlc_rx_fifo_stat;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_vld = 1'b0, in_som = 1'b0, in_eom = 1'b0, in_crc_ok = 1'b0, in_abort = 1'b0;
    logic [7:0] in_byte = '0;
    logic       rd_stb = 1'b0, rd_sel = 1'b0;
    logic [7:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    hdlc_rx_fifo_stat dut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_byte(in_byte),
        .in_som(in_som), .in_eom(in_eom), .in_crc_ok(in_crc_ok),
        .in_abort(in_abort), .rd_stb(rd_stb), .rd_sel(rd_sel), .rd_data(rd_data)
    );

    // Vector: [13:6] byte, [5] som, [4] eom, [3] crc ok, [2] exp open, [1] exp close, [0] exp good
    localparam logic [13:0] VEC [6] = '{
        {8'hA1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        {8'hB2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'hC3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
        {8'hD4, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
        {8'hE5, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        {8'hF6, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b, input logic s, input logic e, input logic ok);
        @(negedge clk);
        in_vld = 1'b1; in_byte = b; in_som = s; in_eom = e; in_crc_ok = ok;
        @(negedge clk);
        in_vld = 1'b0; in_som = 1'b0; in_eom = 1'b0; in_crc_ok = 1'b0;
    endtask

    // Read with strobe; value sampled mid-cycle before the side-effect edge.
    task automatic rd(input logic sel, output logic [7:0] val);
        @(negedge clk);
        rd_stb = 1'b1; rd_sel = sel;
        #1 val = rd_data;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state
        rd(1'b0, v); check("R2 reset status", v, 8'h08);
        // R12 data read while empty
        rd(1'b1, v); check("R12 empty data read", v, 8'h00);
        rd(1'b0, v); check("R12 status unchanged", v, 8'h08);

        // Vector table: push all, then read back
        foreach (VEC[i]) push(VEC[i][13:6], VEC[i][5], VEC[i][4], VEC[i][3]);
        // R1 R9 R10: crc error + valid message + head opening
        rd(1'b0, v); check("R1 R9 R10 status after table", v, 8'h51);
        foreach (VEC[i]) begin
            rd(1'b0, v);
            // R4 R5 R6 head tags, sticky bits now clear (R11)
            check("R4 R5 R6 R11 head status", v, {5'b00000, VEC[i][0], VEC[i][1], VEC[i][2]});
            rd(1'b1, v);
            check("R3 data order", v, VEC[i][13:6]);
        end
        rd(1'b0, v); check("R2 empty after drain", v, 8'h08);

        // R7 overrun: 17 bytes, last dropped
        for (int k = 0; k < 17; k++) push(8'(8'h10 + k), k == 0, 1'b0, 1'b0);
        rd(1'b0, v); check("R7 overrun flag", v, 8'h21);
        for (int k = 0; k < 16; k++) begin
            rd(1'b1, v);
            check("R3 R7 drain order", v, 8'(8'h10 + k));
        end
        rd(1'b0, v); check("R7 dropped byte absent", v, 8'h08);
        // R6 message spoiled by drop: end byte not good
        push(8'h5A, 1'b0, 1'b1, 1'b1);
        rd(1'b0, v); check("R6 R10 overrun spoils good", v, 8'h12);
        rd(1'b1, v); check("R3 lone end byte", v, 8'h5A);

        // R8 abort mid-message
        push(8'h61, 1'b1, 1'b0, 1'b0);
        @(negedge clk); in_abort = 1'b1;
        @(negedge clk); in_abort = 1'b0;
        push(8'h62, 1'b0, 1'b1, 1'b1);
        rd(1'b0, v); check("R8 abort flag", v, 8'h91);
        rd(1'b1, v); check("R3 abort msg byte0", v, 8'h61);
        rd(1'b0, v); check("R6 R8 abort spoils good", v, 8'h02);
        rd(1'b1, v);

        // R11 event and clearing read in the same cycle
        @(negedge clk);
        rd_stb = 1'b1; rd_sel = 1'b0; in_abort = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0; in_abort = 1'b0;
        rd(1'b0, v); check("R11 event wins over clear", v, 8'h88);
        rd(1'b0, v); check("R11 cleared after read", v, 8'h08);

        // R7 pop and write in the same cycle at full
        for (int k = 0; k < 16; k++) push(8'(8'h80 + k), k == 0, 1'b0, 1'b0);
        @(negedge clk);
        rd_stb = 1'b1; rd_sel = 1'b1; in_vld = 1'b1; in_byte = 8'h77;
        #1 check("R3 head before simultaneous pop", rd_data, 8'h80);
        @(negedge clk);
        rd_stb = 1'b0; in_vld = 1'b0;
        rd(1'b0, v); check("R7 no overrun on pop+write", v, 8'h00);
        for (int k = 1; k < 16; k++) begin
            rd(1'b1, v);
            check("R3 full drain", v, 8'(8'h80 + k));
        end
        rd(1'b1, v); check("R7 simultaneous byte kept", v, 8'h77);
        rd(1'b0, v); check("R2 empty at end", v, 8'h08);

        // R2 reset clears content and flags
        push(8'h33, 1'b1, 1'b1, 1'b0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(1'b0, v); check("R2 reset clears", v, 8'h08);

        finish_run();
    end
endmodule